// File: doc/BRIEF.md
# Access-Typed Status Register Bank

A bank of one-bit fields that software reaches over a word-addressed bus. At elaboration every field gets one of thirteen access behaviours: plain storage, a registered copy of a hardware input, an unregistered pass-through of a hardware input, a sticky level latch, a sticky edge capture, a write-triggered one-cycle strobe, or storage loaded from hardware once after reset. The sticky kinds clear either when their word is read or when software writes a one to their bit.

The bus has an address, write data, a write enable, a read enable and combinational read data. Words `0 .. NUM_WORDS-1` hold the fields. Words `NUM_WORDS .. 2*NUM_WORDS-1` hold one interrupt-enable bit per field. A single registered interrupt line reports any enabled edge capture. Each field has one hardware input bit and one hardware output bit.

Top module: `stsreg_bank`

## Requirements
- R1: A plain field (code 0) stores the written bit, reads it back, and drives it on its hardware output.
- R2: A mirrored field (code 1) reads the hardware input as it was at the previous clock edge, so a change shows up one cycle late. Bus writes to it have no effect.
- R3: A pass-through field (code 2) has no storage. Its read bit equals the hardware input in the same cycle.
- R4: Level latches that clear on read set while their input is high (code 3) or low (code 4). They stay set until a read of their word, and that read returns 1.
- R5: Level latches that clear by mask set while their input is high (code 5) or low (code 6). Reads do not clear them. Writing 1 to the bit clears it; writing 0 leaves it set.
- R6: When a set condition and a clear request hit the same bit in the same cycle, the bit ends up set.
- R7: Edge fields set on a rising edge (codes 7 and 9) or a falling edge (codes 8 and 10). A steady level does not set them again. Codes 7 and 8 clear on read; codes 9 and 10 clear on a written 1.
- R8: Enable word k (address NUM_WORDS+k) is read/write and gates fields 16k..16k+15. The interrupt output goes high one cycle after any edge field (codes 7-10) is both captured and enabled. Latch fields never raise it.
- R9: A strobe field (code 11) stores the written bit. Its hardware output is high for exactly the one cycle after a write of 1 to it, and stays low after a write of 0.
- R10: A load-once field (code 12) takes the hardware input on the first clock edge after reset release, and then behaves as a plain field.
- R11: After reset every stored bit, enable bit, strobe output and the interrupt output is 0. The only exception is the load-once fields, which hold their sampled input.
- R12: Field i lives in word i/16 at bit i%16, and its code is i mod 13. An address outside both ranges reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | AW (2) | Word address |
| wr_en | input | 1 | Write strobe for the addressed word |
| wr_data | input | DATA_W (16) | Write data |
| rd_en | input | 1 | Read strobe; clears clear-on-read bits of the addressed word at the edge |
| rd_data | output | DATA_W (16) | Addressed word, combinational |
| hw_in | input | NF (32) | Per-field hardware inputs |
| hw_out | output | NF (32) | Per-field hardware outputs |
| irq | output | 1 | Registered interrupt request |

## Verification
On every cycle, the assertions check the following: set-over-clear priority, clear-on-read and mask-hold behaviour, the one-cycle strobe, the one-cycle lag of mirrored fields, the load-once sample, and the relation between enabled captures and the interrupt line. The bench scenarios cover what a single-field property cannot. These are edge detection under a held level, the correct input polarity for each latch kind, the address map and enable readback, the fact that latch fields are excluded from the interrupt, and the reset image of whole words.

// File: rtl/stsreg_pkg.sv
// Package: field access codes and the default per-field assignment.
// Assumes one bit per field; the code of field i is i modulo NUM_TYPES.
package stsreg_pkg;
    localparam int NUM_TYPES = 13;

    typedef enum logic [3:0] {
        FT_RW      = 4'd0,   // plain storage
        FT_MIRROR  = 4'd1,   // registered copy of hw input
        FT_PASS    = 4'd2,   // combinational pass-through
        FT_LVHI_RD = 4'd3,   // latch on high, clear on read
        FT_LVLO_RD = 4'd4,   // latch on low, clear on read
        FT_LVHI_WC = 4'd5,   // latch on high, write-1 clear
        FT_LVLO_WC = 4'd6,   // latch on low, write-1 clear
        FT_RISE_RD = 4'd7,   // rising edge, clear on read
        FT_FALL_RD = 4'd8,   // falling edge, clear on read
        FT_RISE_WC = 4'd9,   // rising edge, write-1 clear
        FT_FALL_WC = 4'd10,  // falling edge, write-1 clear
        FT_STROBE  = 4'd11,  // stored bit plus one-cycle pulse on write of 1
        FT_LOADONE = 4'd12   // sampled once after reset, then plain
    } ftype_e;

    // Access code assigned to field idx.
    function automatic ftype_e field_type(input int idx);
        return ftype_e'(4'(idx % NUM_TYPES));
    endfunction
endpackage

// File: rtl/stsreg_field.sv
// One-bit field cell. Behaviour is selected by TYPE at elaboration.
// Assumes wr_hit/rd_hit are already qualified by the address decode and
// first_cyc is high only up to the first clock edge after reset release.
module stsreg_field #(
    parameter stsreg_pkg::ftype_e TYPE = stsreg_pkg::FT_RW
) (
    input  logic clk,
    input  logic rst_n,
    input  logic first_cyc,
    input  logic hw_in,
    input  logic wr_hit,
    input  logic wr_bit,
    input  logic rd_hit,
    output logic rd_bit,
    output logic hw_out,
    output logic cap
);
    import stsreg_pkg::*;

    logic q;
    logic prev;
    logic pulse;
    logic set_c;
    logic clr_c;

    // Set condition: level or edge according to the field kind.
    always_comb begin
        case (TYPE)
            FT_LVHI_RD, FT_LVHI_WC: set_c = hw_in;
            FT_LVLO_RD, FT_LVLO_WC: set_c = ~hw_in;
            FT_RISE_RD, FT_RISE_WC: set_c = hw_in & ~prev;
            FT_FALL_RD, FT_FALL_WC: set_c = ~hw_in & prev;
            default:                set_c = 1'b0;
        endcase
    end

    // Clear request: read of the word or write of a one, by kind.
    always_comb begin
        case (TYPE)
            FT_LVHI_RD, FT_LVLO_RD, FT_RISE_RD, FT_FALL_RD: clr_c = rd_hit;
            FT_LVHI_WC, FT_LVLO_WC, FT_RISE_WC, FT_FALL_WC: clr_c = wr_hit & wr_bit;
            default:                                        clr_c = 1'b0;
        endcase
    end

    // Field storage update; sticky kinds let a set beat a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else begin
            case (TYPE)
                FT_RW, FT_STROBE: if (wr_hit) q <= wr_bit;
                FT_LOADONE: begin
                    if (first_cyc)   q <= hw_in;
                    else if (wr_hit) q <= wr_bit;
                end
                FT_MIRROR: q <= hw_in;
                FT_PASS:   q <= 1'b0;
                default:   q <= set_c | (q & ~clr_c);
            endcase
        end
    end

    // Delayed input copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= hw_in;
    end

    // One-cycle strobe after a write of one.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse <= 1'b0;
        else        pulse <= (TYPE == FT_STROBE) && wr_hit && wr_bit;
    end

    // Output selection per kind.
    always_comb begin
        rd_bit = (TYPE == FT_PASS) ? hw_in : q;
        case (TYPE)
            FT_RW, FT_LOADONE: hw_out = q;
            FT_STROBE:         hw_out = pulse;
            default:           hw_out = 1'b0;
        endcase
        cap = (TYPE inside {FT_RISE_RD, FT_FALL_RD, FT_RISE_WC, FT_FALL_WC}) ? q : 1'b0;
    end

    if (TYPE inside {FT_LVHI_RD, FT_LVLO_RD, FT_LVHI_WC, FT_LVLO_WC,
                     FT_RISE_RD, FT_FALL_RD, FT_RISE_WC, FT_FALL_WC}) begin : g_sticky
        // R6: a set is never lost to a simultaneous clear
        p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
            set_c |=> q);
    end

    if (TYPE inside {FT_LVHI_RD, FT_LVLO_RD, FT_RISE_RD, FT_FALL_RD}) begin : g_rdclr
        // R4: a read without a new set leaves the bit clear
        p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_hit && !set_c) |=> !q);
    end

    if (TYPE inside {FT_LVHI_WC, FT_LVLO_WC, FT_RISE_WC, FT_FALL_WC}) begin : g_wrclr
        // R5: only a written one removes a set bit
        p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (q && !(wr_hit && wr_bit)) |=> q);
    end

    if (TYPE == FT_STROBE) begin : g_strobe
        // R9: pulse follows a write of one, and only that
        p_strobe_fire_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_hit && wr_bit) |=> hw_out);
        p_strobe_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
            hw_out |-> $past(wr_hit && wr_bit));
    end

    if (TYPE == FT_MIRROR) begin : g_mirror
        // R2: read value lags the input by one edge
        p_mirror_lag_r2: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (rd_bit == $past(hw_in)));
    end

    if (TYPE == FT_LOADONE) begin : g_load
        // R10: first edge after release loads the input
        p_load_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
            first_cyc |=> (q == $past(hw_in)));
    end
endmodule

// File: rtl/stsreg_irq.sv
// Interrupt-enable words and the registered interrupt request.
// Assumes enable words sit at addresses NUM_WORDS .. 2*NUM_WORDS-1.
module stsreg_irq #(
    parameter int NUM_WORDS = 2,
    parameter int DATA_W    = 16,
    parameter int AW        = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [AW-1:0]                 addr,
    input  logic                          wr_en,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic [NUM_WORDS*DATA_W-1:0]   cap,
    output logic [NUM_WORDS*DATA_W-1:0]   en_q,
    output logic                          irq
);
    // Enable word storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else begin
            for (int w = 0; w < NUM_WORDS; w++) begin
                if (wr_en && addr == AW'(NUM_WORDS + w))
                    en_q[w*DATA_W +: DATA_W] <= wr_data;
            end
        end
    end

    // Registered OR of enabled captures.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |(cap & en_q);
    end

    // R8: an enabled capture raises the line on the next cycle
    p_irq_raise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|(cap & en_q)) |=> irq);
    // R8: the line is never high without an enabled capture behind it
    p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(|(cap & en_q)));
endmodule

// File: rtl/stsreg_rdmux.sv
// Combinational read multiplexer over field words and enable words.
// Assumes addresses beyond 2*NUM_WORDS-1 return zero.
module stsreg_rdmux #(
    parameter int NUM_WORDS = 2,
    parameter int DATA_W    = 16,
    parameter int AW        = 2
) (
    input  logic [AW-1:0]               addr,
    input  logic [NUM_WORDS*DATA_W-1:0] fld_rd,
    input  logic [NUM_WORDS*DATA_W-1:0] en_q,
    output logic [DATA_W-1:0]           rd_data
);
    // Select the addressed word.
    always_comb begin
        rd_data = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (addr == AW'(w))             rd_data = fld_rd[w*DATA_W +: DATA_W];
            if (addr == AW'(NUM_WORDS + w)) rd_data = en_q[w*DATA_W +: DATA_W];
        end
    end
endmodule

// File: rtl/stsreg_bank.sv
// Top: address decode, one field cell per bit, enables, interrupt, read mux.
// Assumes single-cycle bus accesses; a read clears at the edge where rd_en is high.
module stsreg_bank #(
    parameter int NUM_WORDS = 2,
    parameter int DATA_W    = 16,
    localparam int NF       = NUM_WORDS * DATA_W,
    localparam int AW       = (2 * NUM_WORDS > 2) ? $clog2(2 * NUM_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic [NF-1:0]     hw_in,
    output logic [NF-1:0]     hw_out,
    output logic              irq
);
    logic              first_cyc;
    logic [NF-1:0]     fld_rd;
    logic [NF-1:0]     cap;
    logic [NF-1:0]     en_q;

    // Marks the first clock edge after reset release.
    always_ff @(posedge clk) begin
        if (!rst_n) first_cyc <= 1'b1;
        else        first_cyc <= 1'b0;
    end

    for (genvar i = 0; i < NF; i++) begin : g_fld
        localparam int WORD = i / DATA_W;
        localparam int BIT  = i % DATA_W;
        logic wr_hit;
        logic rd_hit;

        // Word-select qualifiers for this field.
        always_comb begin
            wr_hit = wr_en && (addr == AW'(WORD));
            rd_hit = rd_en && (addr == AW'(WORD));
        end

        stsreg_field #(
            .TYPE(stsreg_pkg::field_type(i))
        ) u_field (
            .clk      (clk),
            .rst_n    (rst_n),
            .first_cyc(first_cyc),
            .hw_in    (hw_in[i]),
            .wr_hit   (wr_hit),
            .wr_bit   (wr_data[BIT]),
            .rd_hit   (rd_hit),
            .rd_bit   (fld_rd[i]),
            .hw_out   (hw_out[i]),
            .cap      (cap[i])
        );
    end

    stsreg_irq #(
        .NUM_WORDS(NUM_WORDS),
        .DATA_W   (DATA_W),
        .AW       (AW)
    ) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (addr),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .cap    (cap),
        .en_q   (en_q),
        .irq    (irq)
    );

    stsreg_rdmux #(
        .NUM_WORDS(NUM_WORDS),
        .DATA_W   (DATA_W),
        .AW       (AW)
    ) u_rdmux (
        .addr   (addr),
        .fld_rd (fld_rd),
        .en_q   (en_q),
        .rd_data(rd_data)
    );

    // R11: the interrupt line is low on the first cycle out of reset
    p_irq_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
        first_cyc |-> !irq);
endmodule

// File: tb/stsreg_bank_bench.sv
// Directed sweep over every access kind of the default two-word bank.
module stsreg_bank_bench;
    import stsreg_pkg::*;

    localparam int NW = 2;
    localparam int DW = 16;
    localparam int NF = NW * DW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    addr = '0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en = 1'b0;
    logic [DW-1:0] rd_data;
    logic [NF-1:0] hw_in = '0;
    logic [NF-1:0] hw_out;
    logic          irq;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    stsreg_bank #(.NUM_WORDS(NW), .DATA_W(DW)) u_stsreg_bank (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .hw_in(hw_in), .hw_out(hw_out), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rd_data;
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic pulse_in(input int idx, input logic lvl);
        @(negedge clk); hw_in[idx] = lvl;
        @(negedge clk); hw_in[idx] = ~lvl;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] d;
        // Idle levels: low-polarity latches held high, load-once field 12 fed a 1.
        for (int i = 0; i < NF; i++)
            if (field_type(i) inside {FT_LVLO_RD, FT_LVLO_WC}) hw_in[i] = 1'b1;
        hw_in[12] = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1;

        // R11 / R10: reset image
        rd(2'd0, d); chk("R11 word0 reset", 32'(d), 32'h1000);
        rd(2'd1, d); chk("R11 word1 reset", 32'(d), 32'h0000);
        rd(2'd2, d); chk("R11 enable reset", 32'(d), 32'h0000);
        chk("R11 irq reset", 32'(irq), 32'd0);
        chk("R11 hw_out reset", hw_out, 32'h0000_1000);

        // R10: later input changes do not reload
        @(negedge clk) hw_in[12] = 1'b0;
        repeat (2) @(posedge clk);
        rd(2'd0, d); chk("R10 load-once holds", 32'(d[12]), 32'd1);

        // R1 / R9: write all ones
        chk("R9 strobe idle", 32'(hw_out[11]), 32'd0);
        wr(2'd0, 16'hFFFF);
        chk("R9 strobe pulse", 32'(hw_out[11]), 32'd1);
        @(posedge clk); #1;
        chk("R9 strobe one cycle", 32'(hw_out[11]), 32'd0);
        chk("R1 hw_out", 32'({hw_out[13], hw_out[0]}), 32'd3);
        rd(2'd0, d); chk("R1 readback", 32'(d), 32'h3801);
        wr(2'd0, 16'h0000);
        chk("R9 write zero no pulse", 32'(hw_out[11]), 32'd0);
        rd(2'd0, d); chk("R1 cleared", 32'(d & 16'h3801), 32'h0000);

        // R2: mirrored field lags one cycle, ignores writes
        @(negedge clk) addr = 2'd0; hw_in[1] = 1'b1;
        #1 chk("R2 lag before edge", 32'(rd_data[1]), 32'd0);
        @(posedge clk); #1 chk("R2 after edge", 32'(rd_data[1]), 32'd1);
        wr(2'd0, 16'h0000);
        rd(2'd0, d); chk("R2 write ignored", 32'(d[1]), 32'd1);

        // R3: pass-through same cycle
        @(negedge clk) addr = 2'd0; hw_in[2] = 1'b1;
        #1 chk("R3 pass high", 32'(rd_data[2]), 32'd1);
        hw_in[2] = 1'b0;
        #1 chk("R3 pass low", 32'(rd_data[2]), 32'd0);

        // R4: level latches clear on read, both polarities
        pulse_in(3, 1'b1);
        rd(2'd0, d); chk("R4 high latch set", 32'(d[3]), 32'd1);
        rd(2'd0, d); chk("R4 high latch cleared", 32'(d[3]), 32'd0);
        pulse_in(4, 1'b0);
        rd(2'd0, d); chk("R4 low latch set", 32'(d[4]), 32'd1);
        rd(2'd0, d); chk("R4 low latch cleared", 32'(d[4]), 32'd0);

        // R5: mask-cleared latches
        pulse_in(5, 1'b1);
        rd(2'd0, d); rd(2'd0, d); chk("R5 read keeps", 32'(d[5]), 32'd1);
        wr(2'd0, 16'h0000);
        rd(2'd0, d); chk("R5 write zero keeps", 32'(d[5]), 32'd1);
        wr(2'd0, 16'h0020);
        rd(2'd0, d); chk("R5 write one clears", 32'(d[5]), 32'd0);
        pulse_in(6, 1'b0);
        rd(2'd0, d); chk("R5 low latch set", 32'(d[6]), 32'd1);
        wr(2'd0, 16'h0040);
        rd(2'd0, d); chk("R5 low latch cleared", 32'(d[6]), 32'd0);

        // R6: set and clear in the same cycle
        @(negedge clk) hw_in[5] = 1'b1;
        wr(2'd0, 16'h0020);
        @(negedge clk) hw_in[5] = 1'b0;
        rd(2'd0, d); chk("R6 set wins", 32'(d[5]), 32'd1);
        wr(2'd0, 16'h0020);
        rd(2'd0, d); chk("R6 then clears", 32'(d[5]), 32'd0);

        // R7: edge capture, no recapture on a held level
        @(negedge clk) hw_in[7] = 1'b1;
        rd(2'd0, d); chk("R7 rise captured", 32'(d[7]), 32'd1);
        rd(2'd0, d); chk("R7 rise cleared", 32'(d[7]), 32'd0);
        rd(2'd0, d); chk("R7 held level no recapture", 32'(d[7]), 32'd0);
        @(negedge clk) hw_in[7] = 1'b0; hw_in[8] = 1'b1;
        rd(2'd0, d); chk("R7 fall ignores rise", 32'(d[8]), 32'd0);
        @(negedge clk) hw_in[8] = 1'b0;
        rd(2'd0, d); chk("R7 fall captured", 32'(d[8]), 32'd1);
        pulse_in(10, 1'b1);
        rd(2'd0, d); chk("R7 fall mask-type captured", 32'(d[10]), 32'd1);
        wr(2'd0, 16'h0400);
        rd(2'd0, d); chk("R7 fall mask-type cleared", 32'(d[10]), 32'd0);

        // R8: enable gating and registered interrupt
        pulse_in(9, 1'b1);
        chk("R8 disabled no irq", 32'(irq), 32'd0);
        wr(2'd2, 16'h0200);
        chk("R8 irq not yet", 32'(irq), 32'd0);
        @(posedge clk); #1 chk("R8 irq raised", 32'(irq), 32'd1);
        rd(2'd2, d); chk("R8 enable readback", 32'(d), 32'h0200);
        wr(2'd0, 16'h0200);
        @(posedge clk); #1 chk("R8 irq dropped", 32'(irq), 32'd0);
        wr(2'd2, 16'h0020);
        pulse_in(5, 1'b1);
        repeat (3) @(posedge clk); #1;
        chk("R8 latch never interrupts", 32'(irq), 32'd0);
        wr(2'd0, 16'h0020);

        // R12: second word mapping and enable word 1
        pulse_in(16, 1'b1);
        rd(2'd1, d); chk("R12 field16 in word1 bit0", 32'(d[0]), 32'd1);
        wr(2'd3, 16'hABCD);
        rd(2'd3, d); chk("R12 enable word1", 32'(d), 32'hABCD);
        rd(2'd2, d); chk("R12 enable word0 separate", 32'(d), 32'h0020);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule